// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Sequencer with Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. A client hands it one write request (an 11-bit location and an 8-bit value) over a valid/ready handshake. The sequencer latches the request and drives the active-low chip-select, read-strobe and write-strobe lines. It holds the read strobe inactive around a write-strobe pulse whose setup, width and hold are counted in clock cycles. It drives the data bus only while the write is in progress.

The device then programs the byte on its own. The sequencer finds the end of that internal cycle by reading the same location again and again, with an idle gap before each read, until the most significant data bit reads back equal to the bit that was written. While programming is still in progress the device returns the inverse of that bit. A cycle budget, set from the worst-case programming time, bounds the polling. When the budget is used up without a match, the sequencer ends with a timeout status. Exactly one status pulse ends each request, and no further request is taken until that pulse has been issued.

Top module: `eeprom_bytewr_seq`

## Requirements
- R1: During and directly after reset, chip-select, read strobe and write strobe are all high, the data bus is not driven (`bus_oe`=0), `req_ready`=1 and `done_valid`=0.
- R2: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from then until the cycle after the one-cycle `done_valid` pulse, so exactly one status pulse follows each accepted request.
- R3: A write shows, in order, SETUP_CYC cycles of {ce_n,oe_n,we_n}=011, exactly PULSE_CYC cycles of 010, and HOLD_CYC cycles of 011. The read strobe is high whenever the write strobe is low, and it stays high in the cycle after the write strobe rises.
- R4: From the start of setup to the end of hold, `bus_oe`=1, `bus_out` carries the latched data and `mem_addr` carries the latched location. Both stay unchanged even if the request inputs change after acceptance. `bus_oe`=0 whenever the read strobe is low.
- R5: Each poll round is GAP_CYC cycles with all strobes high (111), followed by READ_CYC cycles of 001 at the written location. `poll_bit` (data bit 7 of the device) is sampled on the last read cycle.
- R6: When the sampled `poll_bit` equals bit 7 of the written data, `done_valid` rises in the next cycle with `done_timeout`=0.
- R7: A sampled `poll_bit` that differs, while the budget is not used up, starts another poll round and produces no status.
- R8: Poll cycles are counted from the first gap cycle. When a sample differs and at least TIMEOUT_CYC poll cycles have passed, including the sampling cycle, `done_valid` rises in the next cycle with `done_timeout`=1.
- R9: A matching sample taken in the same cycle as the budget runs out is reported as success (`done_timeout`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Byte location to program |
| req_data | input | DATA_W | Byte value to program |
| done_valid | output | 1 | One-cycle completion pulse |
| done_timeout | output | 1 | With `done_valid`: 1 = budget ran out, 0 = success |
| mem_addr | output | ADDR_W | Device address lines |
| mem_ce_n | output | 1 | Device chip-select, active low |
| mem_oe_n | output | 1 | Device read strobe, active low |
| mem_we_n | output | 1 | Device write strobe, active low |
| bus_out | output | DATA_W | Data driven toward the device |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| poll_bit | input | 1 | Data bit 7 read from the device |

## Verification
Two events can land in the same cycle: the final poll sample and the running-out of the timeout budget. The bench sets the budget to an exact whole number of poll rounds. Its device model returns the inverted bit for a chosen number of reads, so one request gets its first matching read on precisely the last sample the budget allows. That request must end with success, while a request that fails one read more must end with a timeout after the same number of reads. Strobe phase lengths are measured from the port levels and compared against the parameters.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_PGAP,
    ST_PREAD,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

  // Pin levels wanted for each sequencer state.
  function automatic strobe_t strobe_for(input seq_state_e s);
    strobe_t r;
    r = STROBE_QUIET;
    case (s)
      ST_WSETUP, ST_WHOLD: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      ST_WPULSE:           r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_PREAD:            r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      default:             r = STROBE_QUIET;
    endcase
    return r;
  endfunction

  // Budget rule: spent cycles (sampling cycle included) reach the limit.
  function automatic logic poll_limit_hit(input int unsigned spent, input int unsigned limit);
    return spent >= limit;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprom_phase_timer.sv
module eeprom_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             phase_end
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign phase_end = (cnt_q == '0);
endmodule

// File: rtl/eeprom_poll_timer.sv
module eeprom_poll_timer
  import eeprom_seq_pkg::*;
#(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1) + 1;
  localparam logic [TW-1:0] SAT = TW'(LIMIT);

  logic [TW-1:0] spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spent_q <= '0;
    end else if (clear) begin
      spent_q <= '0;
    end else if (run && spent_q < SAT) begin
      spent_q <= spent_q + 1'b1;
    end
  end

  // The current cycle counts toward the budget.
  assign expired = poll_limit_hit(32'(spent_q) + 32'd1, 32'(LIMIT));
endmodule

// File: rtl/eeprom_strobe_reg.sv
module eeprom_strobe_reg
  import eeprom_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t nxt,
  output strobe_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= STROBE_QUIET;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/eeprom_bytewr_seq.sv
module eeprom_bytewr_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 3,
  parameter int PULSE_CYC   = 40,
  parameter int HOLD_CYC    = 3,
  parameter int GAP_CYC     = 2,
  parameter int READ_CYC    = 52,
  parameter int TIMEOUT_CYC = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done_valid,
  output logic              done_timeout,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic              poll_bit
);
  localparam int LEN_MAX = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(HOLD_CYC, GAP_CYC)), READ_CYC);
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  seq_state_e        state_q, state_d;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              phase_end;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              tmo_q, tmo_d;
  strobe_t           strobe_cur;

  // Named internal events, used by the bound checker.
  logic poll_sample;
  logic poll_match;
  logic poll_expired;

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign poll_match = (poll_bit == data_q[DATA_W-1]);

  always_comb begin
    state_d     = state_q;
    load        = 1'b0;
    load_val    = '0;
    tmo_d       = tmo_q;
    poll_sample = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_WSETUP;
          load     = 1'b1;
          load_val = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_WSETUP: begin
        if (phase_end) begin
          state_d  = ST_WPULSE;
          load     = 1'b1;
          load_val = CNT_W'(PULSE_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (phase_end) begin
          state_d  = ST_WHOLD;
          load     = 1'b1;
          load_val = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (phase_end) begin
          state_d  = ST_PGAP;
          load     = 1'b1;
          load_val = CNT_W'(GAP_CYC - 1);
        end
      end
      ST_PGAP: begin
        if (phase_end) begin
          state_d  = ST_PREAD;
          load     = 1'b1;
          load_val = CNT_W'(READ_CYC - 1);
        end
      end
      ST_PREAD: begin
        if (phase_end) begin
          poll_sample = 1'b1;
          if (poll_match) begin
            state_d = ST_DONE;
            tmo_d   = 1'b0;
          end else if (poll_expired) begin
            state_d = ST_DONE;
            tmo_d   = 1'b1;
          end else begin
            state_d  = ST_PGAP;
            load     = 1'b1;
            load_val = CNT_W'(GAP_CYC - 1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  eeprom_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .phase_end(phase_end)
  );

  eeprom_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q == ST_WHOLD),
    .run    ((state_q == ST_PGAP) || (state_q == ST_PREAD)),
    .expired(poll_expired)
  );

  eeprom_strobe_reg u_pins (
    .clk  (clk),
    .rst_n(rst_n),
    .nxt  (strobe_for(state_d)),
    .cur  (strobe_cur)
  );

  assign mem_ce_n     = strobe_cur.ce_n;
  assign mem_oe_n     = strobe_cur.oe_n;
  assign mem_we_n     = strobe_cur.we_n;
  assign bus_oe       = strobe_cur.drive;
  assign bus_out      = data_q;
  assign mem_addr     = addr_q;
  assign req_ready    = (state_q == ST_IDLE);
  assign done_valid   = (state_q == ST_DONE);
  assign done_timeout = tmo_q;
endmodule

// File: rtl/eeprom_bytewr_seq_chk.sv
module eeprom_bytewr_seq_chk #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done_valid,
  input logic              done_timeout,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              poll_sample,
  input logic              poll_match,
  input logic              poll_expired
);
  localparam int PW = $clog2(PULSE_CYC + 2) + 1;
  logic [PW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!mem_we_n) begin
      if (low_run != '1) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  a_r4_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !bus_oe);

  a_r3_write_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && bus_oe));

  a_r3_oe_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_oe_n);

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_run == PW'(PULSE_CYC)));

  a_r4_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(bus_out) && $stable(mem_addr)));

  a_r2_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  a_r6_match_done: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_sample && poll_match) |=> (done_valid && !done_timeout));

  a_r8_expire_done: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_sample && !poll_match && poll_expired) |=> (done_valid && done_timeout));

  a_r7_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_sample && !poll_match && !poll_expired) |=> (!done_valid && mem_oe_n && mem_ce_n));
endmodule

bind eeprom_bytewr_seq eeprom_bytewr_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .done_valid  (done_valid),
  .done_timeout(done_timeout),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .bus_oe      (bus_oe),
  .bus_out     (bus_out),
  .mem_addr    (mem_addr),
  .poll_sample (poll_sample),
  .poll_match  (poll_match),
  .poll_expired(poll_expired)
);

// File: tb/eeprom_bytewr_seq_test.sv
module eeprom_bytewr_seq_test;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;
  localparam int GAP   = 2;
  localparam int READ  = 3;
  localparam int TMO   = 20;
  localparam int ROUND = GAP + READ;
  localparam int KMAX  = (TMO + ROUND - 1) / ROUND;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        done_valid, done_timeout;
  logic [10:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic        poll_bit;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eeprom_bytewr_seq #(
    .ADDR_W(11), .DATA_W(8), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
    .GAP_CYC(GAP), .READ_CYC(READ), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done_valid(done_valid),
    .done_timeout(done_timeout), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .poll_bit(poll_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard queues filled by the driver.
  logic [18:0] exp_wr_q[$];
  int          fail_q[$];
  bit          exp_tmo_q[$];
  int          exp_reads_q[$];
  int          exp_fails_q[$];

  // Device model state.
  int          rd_idx = 0;
  int          cur_fails = 0;
  logic        wbit7 = 1'b0;
  logic [10:0] waddr = '0;
  always_comb poll_bit = (rd_idx <= cur_fails) ? ~wbit7 : wbit7;

  task automatic send(input logic [10:0] a, input logic [7:0] d, input int fails);
    bit tmo;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    tmo = (fails >= KMAX);
    exp_wr_q.push_back({a, d});
    fail_q.push_back(fails);
    exp_tmo_q.push_back(tmo);
    exp_reads_q.push_back(tmo ? KMAX : fails + 1);
    exp_fails_q.push_back(fails);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_addr  = ~a;
    req_data  = ~d;
  endtask

  // Monitor: strobe segments, write capture, status.
  logic [2:0]  seg_val = 3'b111, seg_before = 3'b111;
  int          seg_len = 0;
  int          outstanding = 0;
  bit          prev_done = 1'b0;
  logic [10:0] cap_addr = '0;
  logic [7:0]  cap_data = '0;

  always @(negedge clk) begin
    logic [2:0] trip;
    if (rst_n) begin
      trip = {mem_ce_n, mem_oe_n, mem_we_n};
      if (trip != seg_val) begin
        if (seg_val == 3'b011 && trip == 3'b010) check(seg_len == SETUP, "R3 setup", seg_len, SETUP);
        if (seg_val == 3'b011 && seg_before == 3'b010) check(seg_len == HOLD, "R3 hold", seg_len, HOLD);
        if (seg_val == 3'b111 && trip == 3'b001) check(seg_len == GAP, "R5 gap", seg_len, GAP);
        if (seg_val == 3'b001) check(seg_len == READ, "R5 read", seg_len, READ);
        if (seg_val == 3'b010) begin
          check(seg_len == PULSE, "R3 pulse", seg_len, PULSE);
          check(exp_wr_q.size() > 0, "R2 unexpected write", 1, 0);
          if (exp_wr_q.size() > 0) begin
            logic [18:0] e;
            e = exp_wr_q.pop_front();
            check({cap_addr, cap_data} == e, "R4 write data", int'({cap_addr, cap_data}), int'(e));
          end
          cur_fails = (fail_q.size() > 0) ? fail_q.pop_front() : 0;
          wbit7 = cap_data[7];
          waddr = cap_addr;
          rd_idx = 0;
          check(mem_oe_n == 1'b1, "R3 oe after we", int'(mem_oe_n), 1);
        end
        if (trip == 3'b001) rd_idx++;
        seg_before = seg_val;
        seg_val = trip;
        seg_len = 1;
      end else begin
        seg_len++;
      end
      if (trip == 3'b010) begin
        cap_addr = mem_addr;
        cap_data = bus_out;
        if (!bus_oe) check(1'b0, "R4 drive in pulse", 0, 1);
      end
      if (trip == 3'b001) begin
        if (bus_oe) check(1'b0, "R4 drive in read", 1, 0);
        if (mem_addr != waddr) check(1'b0, "R5 poll address", int'(mem_addr), int'(waddr));
      end
      if (req_valid && req_ready) begin
        check(outstanding == 0, "R2 accept while busy", outstanding, 0);
        outstanding++;
      end
      if (done_valid) begin
        check(!prev_done, "R2 single pulse", int'(prev_done), 0);
        check(!req_ready, "R2 ready during done", int'(req_ready), 0);
        check(outstanding == 1, "R2 one status per request", outstanding, 1);
        outstanding--;
        if (exp_tmo_q.size() == 0) begin
          check(1'b0, "R2 extra status", 1, 0);
        end else begin
          bit ex_t;
          int ex_r, ex_f;
          ex_t = exp_tmo_q.pop_front();
          ex_r = exp_reads_q.pop_front();
          ex_f = exp_fails_q.pop_front();
          if (ex_f == KMAX - 1)
            check(done_timeout == ex_t, "R9 match on last sample", int'(done_timeout), int'(ex_t));
          else if (ex_t)
            check(done_timeout == ex_t, "R8 timeout status", int'(done_timeout), int'(ex_t));
          else
            check(done_timeout == ex_t, "R6 success status", int'(done_timeout), int'(ex_t));
          check(rd_idx == ex_r, "R7 poll read count", rd_idx, ex_r);
        end
      end
      prev_done = done_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    check(!bus_oe && req_ready && !done_valid, "R1 idle in reset", int'({bus_oe, req_ready, done_valid}), 2);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !bus_oe, "R1 after reset", int'({mem_ce_n, mem_oe_n, mem_we_n, bus_oe}), 14);
    check(req_ready && !done_valid, "R1 ready after reset", int'({req_ready, done_valid}), 2);

    send(11'h000, 8'h5A, 0);
    send(11'h7FF, 8'hA5, 2);
    send(11'h123, 8'h80, KMAX - 1);
    send(11'h456, 8'h01, KMAX);
    send(11'h3C3, 8'hFF, 7);
    send(11'h055, 8'h7F, 1);
    send(11'h2AA, 8'h00, KMAX - 1);

    while (exp_tmo_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(outstanding == 0 && exp_wr_q.size() == 0, "R2 all requests closed", outstanding, 0);
    check(req_ready && mem_ce_n && !bus_oe, "R1 idle at end", int'({req_ready, mem_ce_n, bus_oe}), 6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule